// File: doc/BRIEF.md
# AXI-to-APB Single-Transfer Bridge

This block sits between an AXI interconnect and a group of up to six APB peripherals. On the AXI side it is a 32-bit slave. It accepts single-beat read requests on the read-address channel, and write requests when an address and its data arrive together. Each accepted request becomes exactly one APB transfer, addressed to the peripheral that a three-bit field of the address selects. The result comes back on the AXI read-data channel or the write-response channel.

Accepted requests wait in a small command queue, two entries deep by default. The queue holds the ID, the address, the direction, the write data and any decode error. A controller takes commands from the queue one at a time, and only once the previous response has been handed over. It then runs the APB handshake: a one-cycle setup phase followed by an access phase. The access phase is stretched until the selected peripheral signals ready.

Some commands cannot be executed. If the address field has no peripheral behind it, or the request asks for a burst, the command never touches the APB bus and is answered with an error response.

Top module: `axiApbBridge`

## Requirements
- R1: `arReady` is high exactly while the command queue has a free slot. A write is accepted only when `awValid` and `wValid` are both high, and `awReady`/`wReady` are asserted together. Once the queue holds two commands, both ready outputs are low.
- R2: The peripheral index is `ADDR[14:12]`. Index n in 0..5 drives `pSel` bit n, and at most one `pSel` bit is ever high.
- R3: Only one transfer is active at any time. A command leaves the queue only after the previous response has been accepted by its master. Commands complete in the order they were accepted, so `rValid` and `bValid` are never high together.
- R4: When a read and a write are offered in the same cycle, the read takes the first free slot. With only one slot free, the read is accepted and the write is held off.
- R5: An APB transfer has one setup cycle (`pSel` high, `pEnable` low), then access cycles with `pEnable` high. `pAddr`, `pWrite`, `pWdata` and `pSel` do not change between setup and the end of access. Access ends in the first cycle where the selected peripheral's `pReady` is high.
- R6: Only the selected peripheral's `pReady`, `pSlvErr` and `pRdata` affect the transfer. The others are ignored.
- R7: A read returns `rId` equal to the request ID and `rData` equal to the selected `pRdata` sampled in the final access cycle. `rLast` is always 1. `rResp` is 2'b00 (OKAY), or 2'b10 (SLVERR) when the selected `pSlvErr` was high.
- R8: A write drives `pWrite` high, and `pWdata` equal to the `wData` accepted with the request, on the peripheral from R2. It completes with `bId` equal to the request ID and `bResp` coded as in R7.
- R9: An address with index 6 or 7 produces no APB transfer. It is answered with response 2'b11 (DECERR), and a read also returns `rData` = 0.
- R10: A request whose `arLen`/`awLen` is not 0 produces no APB transfer. It is answered as one beat with response 2'b10 (SLVERR), and a read also returns `rData` = 0.
- R11: `rValid`/`bValid`, together with the ID, data and response that go with them, stay unchanged until `rReady`/`bReady` is seen high.
- R12: After reset, `rValid`, `bValid`, `pSel` and `pEnable` are 0, and `arReady` and `awReady` are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| arValid | input | 1 | Read request valid |
| arReady | output | 1 | Read request accepted |
| arAddr | input | 32 | Read address |
| arId | input | ID_W | Read transaction ID |
| arLen | input | 8 | Read burst length minus one |
| rValid | output | 1 | Read response valid |
| rReady | input | 1 | Read response taken |
| rId | output | ID_W | Read response ID |
| rData | output | 32 | Read data |
| rResp | output | 2 | Read response code |
| rLast | output | 1 | Last beat, always 1 |
| awValid | input | 1 | Write address valid |
| awReady | output | 1 | Write address accepted |
| awAddr | input | 32 | Write address |
| awId | input | ID_W | Write transaction ID |
| awLen | input | 8 | Write burst length minus one |
| wValid | input | 1 | Write data valid |
| wReady | output | 1 | Write data accepted |
| wData | input | 32 | Write data |
| bValid | output | 1 | Write response valid |
| bReady | input | 1 | Write response taken |
| bId | output | ID_W | Write response ID |
| bResp | output | 2 | Write response code |
| pAddr | output | 32 | APB address |
| pSel | output | NUM_SLV | One-hot peripheral select |
| pEnable | output | 1 | APB access phase |
| pWrite | output | 1 | APB direction, 1 = write |
| pWdata | output | 32 | APB write data |
| pReady | input | NUM_SLV | Per-peripheral ready |
| pRdata | input | 32*NUM_SLV | Per-peripheral read data, peripheral n at bits 32n+31..32n |
| pSlvErr | input | NUM_SLV | Per-peripheral error |

## Verification
The APB stability and single-setup properties assume two things about the peripherals. The selected one keeps `pReady` low for as long as it wants the access stretched, and it raises it only during access. The bench's peripheral model follows both rules, while the unselected models hold `pReady` and `pSlvErr` high and drive recognisable junk data. The response-hold properties assume nothing about the master; the bench holds `rReady`/`bReady` low for a random number of cycles before taking each response. Requests are issued and kept valid until accepted. The one exception is the directed queue-full cases, which drop a refused request on purpose.

// File: rtl/bridgePkg.sv
`timescale 1ns/1ps
package bridgePkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 8;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } respE;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACCESS,
    ST_RESP
  } phaseE;

  typedef struct packed {
    logic pop;          // move queue head into the active slot
    logic capture;      // last access cycle: sample selected slave
    logic setupPhase;
    logic accessPhase;
    logic respPhase;
  } ctrlStrobeT;
endpackage

// File: rtl/bridgeCtrl.sv
`timescale 1ns/1ps
module bridgeCtrl
  import bridgePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       queueEmpty,
  input  logic       headSkip,
  input  logic       selReady,
  input  logic       respTaken,
  output ctrlStrobeT strobe
);
  phaseE phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    strobe    = '0;
    unique case (phase)
      ST_IDLE: if (!queueEmpty) begin
        strobe.pop = 1'b1;
        phaseNext  = headSkip ? ST_RESP : ST_SETUP;
      end
      ST_SETUP: begin
        strobe.setupPhase = 1'b1;
        phaseNext         = ST_ACCESS;
      end
      ST_ACCESS: begin
        strobe.accessPhase = 1'b1;
        if (selReady) begin
          strobe.capture = 1'b1;
          phaseNext      = ST_RESP;
        end
      end
      ST_RESP: begin
        strobe.respPhase = 1'b1;
        if (respTaken) phaseNext = ST_IDLE;
      end
      default: phaseNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= ST_IDLE;
    else       phase <= phaseNext;
  end

  AST_ONE_POP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |=> !strobe.pop); // R3
  AST_RESP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.respPhase && respTaken) |=> !strobe.respPhase); // R11
endmodule

// File: rtl/bridgeData.sv
`timescale 1ns/1ps
module bridgeData
  import bridgePkg::*;
#(
  parameter int ID_W    = 4,
  parameter int DEPTH   = 2,
  parameter int NUM_SLV = 6,
  parameter int SEL_LSB = 12,
  parameter int SEL_W   = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobeT                strobe,
  output logic                      queueEmpty,
  output logic                      headSkip,
  output logic                      selReady,
  output logic                      respTaken,
  input  logic                      arValid,
  output logic                      arReady,
  input  logic [ADDR_W-1:0]         arAddr,
  input  logic [ID_W-1:0]           arId,
  input  logic [LEN_W-1:0]          arLen,
  output logic                      rValid,
  input  logic                      rReady,
  output logic [ID_W-1:0]           rId,
  output logic [DATA_W-1:0]         rData,
  output logic [1:0]                rResp,
  output logic                      rLast,
  input  logic                      awValid,
  output logic                      awReady,
  input  logic [ADDR_W-1:0]         awAddr,
  input  logic [ID_W-1:0]           awId,
  input  logic [LEN_W-1:0]          awLen,
  input  logic                      wValid,
  output logic                      wReady,
  input  logic [DATA_W-1:0]         wData,
  output logic                      bValid,
  input  logic                      bReady,
  output logic [ID_W-1:0]           bId,
  output logic [1:0]                bResp,
  output logic [ADDR_W-1:0]         pAddr,
  output logic [NUM_SLV-1:0]        pSel,
  output logic                      pEnable,
  output logic                      pWrite,
  output logic [DATA_W-1:0]         pWdata,
  input  logic [NUM_SLV-1:0]        pReady,
  input  logic [NUM_SLV*DATA_W-1:0] pRdata,
  input  logic [NUM_SLV-1:0]        pSlvErr
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [ADDR_W-1:0] addr;
    logic              isWrite;
    logic [DATA_W-1:0] wdata;
    logic              skip;
    logic [1:0]        errResp;
  } cmdT;

  function automatic cmdT makeCmd(input logic [ADDR_W-1:0] addr, input logic [ID_W-1:0] id,
                                  input logic [LEN_W-1:0] len, input logic isWrite,
                                  input logic [DATA_W-1:0] wdata);
    cmdT c;
    c.id = id; c.addr = addr; c.isWrite = isWrite; c.wdata = wdata;
    if (int'(addr[SEL_LSB +: SEL_W]) >= NUM_SLV) begin
      c.skip = 1'b1; c.errResp = RESP_DECERR;
    end else if (len != '0) begin
      c.skip = 1'b1; c.errResp = RESP_SLVERR;
    end else begin
      c.skip = 1'b0; c.errResp = RESP_OKAY;
    end
    return c;
  endfunction

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // ---------------- command queue ----------------
  cmdT              queueMem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             arPush, wPush, wrReady;
  cmdT              head;

  assign arReady = int'(count) < DEPTH;
  assign wrReady = (int'(count) + (arValid ? 2 : 1)) <= DEPTH;
  assign awReady = wrReady;
  assign wReady  = wrReady;
  assign arPush  = arValid && arReady;
  assign wPush   = awValid && wValid && wrReady;
  assign head    = queueMem[rdPtr];
  assign queueEmpty = (count == '0);
  assign headSkip   = head.skip;

  always_ff @(posedge clk) begin
    if (arPush) queueMem[wrPtr] <= makeCmd(arAddr, arId, arLen, 1'b0, '0);
    if (wPush)  queueMem[arPush ? nextPtr(wrPtr) : wrPtr] <= makeCmd(awAddr, awId, awLen, 1'b1, wData);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (arPush && wPush)     wrPtr <= nextPtr(nextPtr(wrPtr));
      else if (arPush || wPush) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop) rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(arPush) + CNT_W'(wPush) - CNT_W'(strobe.pop);
    end
  end

  // ---------------- active transfer ----------------
  logic [ID_W-1:0]   actId;
  logic [ADDR_W-1:0] actAddr;
  logic              actWrite;
  logic [DATA_W-1:0] actWdata;
  logic [SEL_W-1:0]  actIdx;
  logic [1:0]        respCode;
  logic [DATA_W-1:0] readReg;
  logic [DATA_W-1:0] selRdata;
  logic              selErr;

  always_comb begin
    selRdata = '0;
    selErr   = 1'b0;
    selReady = 1'b0;
    for (int i = 0; i < NUM_SLV; i++) begin
      if (actIdx == SEL_W'(i)) begin
        selRdata = pRdata[i*DATA_W +: DATA_W];
        selErr   = pSlvErr[i];
        selReady = pReady[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actId    <= '0;
      actAddr  <= '0;
      actWrite <= 1'b0;
      actWdata <= '0;
      actIdx   <= '0;
      respCode <= RESP_OKAY;
      readReg  <= '0;
    end else if (strobe.pop) begin
      actId    <= head.id;
      actAddr  <= head.addr;
      actWrite <= head.isWrite;
      actWdata <= head.wdata;
      actIdx   <= head.addr[SEL_LSB +: SEL_W];
      respCode <= head.errResp;
      readReg  <= '0;
    end else if (strobe.capture) begin
      respCode <= selErr ? RESP_SLVERR : RESP_OKAY;
      readReg  <= actWrite ? '0 : selRdata;
    end
  end

  // ---------------- APB drive ----------------
  for (genvar g = 0; g < NUM_SLV; g++) begin : gSel
    assign pSel[g] = (strobe.setupPhase || strobe.accessPhase) && (actIdx == SEL_W'(g));
  end
  assign pEnable = strobe.accessPhase;
  assign pAddr   = actAddr;
  assign pWrite  = actWrite;
  assign pWdata  = actWdata;

  // ---------------- AXI responses ----------------
  assign rValid    = strobe.respPhase && !actWrite;
  assign bValid    = strobe.respPhase && actWrite;
  assign rId       = actId;
  assign bId       = actId;
  assign rResp     = respCode;
  assign bResp     = respCode;
  assign rData     = readReg;
  assign rLast     = 1'b1;
  assign respTaken = (rValid && rReady) || (bValid && bReady);

  // ---------------- checks ----------------
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pSel)); // R2
  AST_ENABLE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rstN)
    pEnable |-> (pSel != '0)); // R5
  AST_SETUP_TO_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    ((pSel != '0) && !pEnable) |=> pEnable && $stable(pSel) && $stable(pAddr)
                                   && $stable(pWrite) && $stable(pWdata)); // R5
  AST_ACCESS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pEnable && !selReady) |=> pEnable && $stable(pSel) && $stable(pAddr) && $stable(pWdata)); // R5
  AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    !arReady |-> !awReady); // R4
  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rstN)
    !(rValid && bValid)); // R3
  AST_R_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && !rReady) |=> rValid && $stable(rData) && $stable(rResp) && $stable(rId)); // R11
  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (bValid && !bReady) |=> bValid && $stable(bResp) && $stable(bId)); // R11
endmodule

// File: rtl/axiApbBridge.sv
`timescale 1ns/1ps
module axiApbBridge
  import bridgePkg::*;
#(
  parameter int ID_W    = 4,
  parameter int DEPTH   = 2,
  parameter int NUM_SLV = 6,
  parameter int SEL_LSB = 12,
  parameter int SEL_W   = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      arValid,
  output logic                      arReady,
  input  logic [ADDR_W-1:0]         arAddr,
  input  logic [ID_W-1:0]           arId,
  input  logic [LEN_W-1:0]          arLen,
  output logic                      rValid,
  input  logic                      rReady,
  output logic [ID_W-1:0]           rId,
  output logic [DATA_W-1:0]         rData,
  output logic [1:0]                rResp,
  output logic                      rLast,
  input  logic                      awValid,
  output logic                      awReady,
  input  logic [ADDR_W-1:0]         awAddr,
  input  logic [ID_W-1:0]           awId,
  input  logic [LEN_W-1:0]          awLen,
  input  logic                      wValid,
  output logic                      wReady,
  input  logic [DATA_W-1:0]         wData,
  output logic                      bValid,
  input  logic                      bReady,
  output logic [ID_W-1:0]           bId,
  output logic [1:0]                bResp,
  output logic [ADDR_W-1:0]         pAddr,
  output logic [NUM_SLV-1:0]        pSel,
  output logic                      pEnable,
  output logic                      pWrite,
  output logic [DATA_W-1:0]         pWdata,
  input  logic [NUM_SLV-1:0]        pReady,
  input  logic [NUM_SLV*DATA_W-1:0] pRdata,
  input  logic [NUM_SLV-1:0]        pSlvErr
);
  ctrlStrobeT strobe;
  logic queueEmpty, headSkip, selReady, respTaken;

  bridgeCtrl uCtrl (
    .clk(clk), .rstN(rstN), .queueEmpty(queueEmpty), .headSkip(headSkip),
    .selReady(selReady), .respTaken(respTaken), .strobe(strobe)
  );

  bridgeData #(
    .ID_W(ID_W), .DEPTH(DEPTH), .NUM_SLV(NUM_SLV), .SEL_LSB(SEL_LSB), .SEL_W(SEL_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .queueEmpty(queueEmpty), .headSkip(headSkip), .selReady(selReady), .respTaken(respTaken),
    .arValid(arValid), .arReady(arReady), .arAddr(arAddr), .arId(arId), .arLen(arLen),
    .rValid(rValid), .rReady(rReady), .rId(rId), .rData(rData), .rResp(rResp), .rLast(rLast),
    .awValid(awValid), .awReady(awReady), .awAddr(awAddr), .awId(awId), .awLen(awLen),
    .wValid(wValid), .wReady(wReady), .wData(wData),
    .bValid(bValid), .bReady(bReady), .bId(bId), .bResp(bResp),
    .pAddr(pAddr), .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite), .pWdata(pWdata),
    .pReady(pReady), .pRdata(pRdata), .pSlvErr(pSlvErr)
  );
endmodule

// File: tb/tb_axiApbBridge.sv
`timescale 1ns/1ps
module tb_axiApbBridge;
  localparam int NS = 6;
  logic clk = 1'b0, rstN = 1'b0;
  logic arValid = 0, arReady; logic [31:0] arAddr = 0; logic [3:0] arId = 0; logic [7:0] arLen = 0;
  logic rValid, rReady = 0, rLast; logic [3:0] rId; logic [31:0] rData; logic [1:0] rResp;
  logic awValid = 0, awReady; logic [31:0] awAddr = 0; logic [3:0] awId = 0; logic [7:0] awLen = 0;
  logic wValid = 0, wReady; logic [31:0] wData = 0;
  logic bValid, bReady = 0; logic [3:0] bId; logic [1:0] bResp;
  logic [31:0] pAddr, pWdata; logic [NS-1:0] pSel; logic pEnable, pWrite;
  logic [NS-1:0] pReady = '1, pSlvErr = '0; logic [NS*32-1:0] pRdata = '0;

  int tests = 0, fails = 0;
  bit stall = 0;
  int waitCycles = 0, waitCnt = 0;
  int apbCount = 0, apbSeen = 0;
  logic [31:0] logAddr [256]; logic logWrite [256]; logic [31:0] logWdata [256];
  bit prevSetup = 0; logic [NS-1:0] setSel; logic [31:0] setAddr, setWdata; logic setWrite;

  always #10 clk = ~clk;

  axiApbBridge dut (.*);

  function automatic logic [31:0] rdFn(input logic [31:0] a, input int i);
    return (a * 32'h9E37_79B1) ^ 32'hC300_0000 ^ 32'(i);
  endfunction
  function automatic bit errFn(input logic [31:0] a);
    return a[3:2] == 2'b11;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // APB peripheral models and protocol monitor
  always @(negedge clk) begin
    int idx;
    idx = -1;
    for (int i = 0; i < NS; i++) if (pSel[i]) idx = i;
    if (prevSetup) begin
      check(pEnable == 1'b1, "R5", "access follows one setup cycle", 32'(pEnable), 1);
    end
    if (pEnable)
      check(pSel == setSel && pAddr == setAddr && pWrite == setWrite && pWdata == setWdata,
            "R5", "APB signals held from setup", pAddr, setAddr);
    prevSetup = (pSel != 0) && !pEnable;
    if (prevSetup) begin
      check($onehot(pSel) && idx == int'(pAddr[14:12]), "R2", "pSel matches ADDR[14:12]",
            32'(pSel), 32'(1) << pAddr[14:12]);
      setSel = pSel; setAddr = pAddr; setWrite = pWrite; setWdata = pWdata;
      waitCycles = $urandom % 4;
    end
    for (int i = 0; i < NS; i++) begin
      if (pSel[i]) begin
        pRdata[i*32 +: 32] = rdFn(pAddr, i);
        pSlvErr[i] = errFn(pAddr);
        pReady[i] = pEnable && !stall && (waitCnt >= waitCycles);
      end else begin
        pRdata[i*32 +: 32] = 32'hBAD0_0000 | 32'(i);
        pSlvErr[i] = 1'b1;
        pReady[i] = 1'b1;
      end
    end
    if (pEnable && idx >= 0 && pReady[idx]) begin
      logAddr[apbCount % 256] = pAddr; logWrite[apbCount % 256] = pWrite;
      logWdata[apbCount % 256] = pWdata; apbCount++;
    end
    if (pEnable) waitCnt++; else waitCnt = 0;
  end

  task automatic issueRead(input logic [31:0] a, input logic [3:0] id, input logic [7:0] len);
    @(negedge clk); arAddr = a; arId = id; arLen = len; arValid = 1; #1;
    while (!arReady) begin @(negedge clk); #1; end
    @(posedge clk); #1; arValid = 0;
  endtask

  task automatic issueWrite(input logic [31:0] a, input logic [3:0] id, input logic [7:0] len,
                            input logic [31:0] d);
    @(negedge clk); awAddr = a; awId = id; awLen = len; wData = d; awValid = 1; wValid = 1; #1;
    while (!awReady) begin @(negedge clk); #1; end
    check(wReady == 1'b1, "R1", "wReady with awReady", 32'(wReady), 1);
    @(posedge clk); #1; awValid = 0; wValid = 0;
  endtask

  // Wait for the next response, check it against the request, and take it.
  task automatic collect(input bit isWr, input logic [31:0] a, input logic [3:0] id,
                         input logic [7:0] len, input logic [31:0] d);
    logic [1:0] expResp; bit expApb; logic [31:0] expData;
    logic [3:0] gotId; logic [1:0] gotResp; logic [31:0] gotData; int hold;
    if (a[14:12] > 3'd5) begin expResp = 2'b11; expApb = 0; expData = 0; end
    else if (len != 0) begin expResp = 2'b10; expApb = 0; expData = 0; end
    else begin
      expApb = 1; expResp = errFn(a) ? 2'b10 : 2'b00;
      expData = isWr ? 32'h0 : rdFn(a, int'(a[14:12]));
    end
    @(negedge clk);
    while (!(rValid || bValid)) @(negedge clk);
    check(bValid == isWr && rValid == !isWr, "R3", "response order/type", 32'(bValid), 32'(isWr));
    gotId = isWr ? bId : rId; gotResp = isWr ? bResp : rResp; gotData = rData;
    check(gotId == id, isWr ? "R8" : "R7", "response ID", 32'(gotId), 32'(id));
    check(gotResp == expResp, expApb ? (isWr ? "R8" : "R7") : (expResp == 2'b11 ? "R9" : "R10"),
          "response code", 32'(gotResp), 32'(expResp));
    if (!isWr) begin
      check(gotData == expData, expApb ? "R6" : "R9", "read data", gotData, expData);
      check(rLast == 1'b1, "R7", "rLast", 32'(rLast), 1);
    end
    if (expApb) begin
      check(apbCount == apbSeen + 1, "R3", "one APB transfer", 32'(apbCount), 32'(apbSeen + 1));
      check(logAddr[apbSeen % 256] == a && logWrite[apbSeen % 256] == isWr, "R8", "APB addr/dir",
            logAddr[apbSeen % 256], a);
      if (isWr) check(logWdata[apbSeen % 256] == d, "R8", "pWdata", logWdata[apbSeen % 256], d);
      apbSeen++;
    end else begin
      check(apbCount == apbSeen, len != 0 ? "R10" : "R9", "no APB transfer", 32'(apbCount), 32'(apbSeen));
    end
    hold = $urandom % 3;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check((isWr ? bValid : rValid) && (isWr ? bId : rId) == gotId && (isWr ? bResp : rResp) == gotResp
            && rData == gotData, "R11", "response held", 32'(isWr ? bResp : rResp), 32'(gotResp));
    end
    if (isWr) bReady = 1; else rReady = 1;
    @(posedge clk); #1; bReady = 0; rReady = 0;
    @(negedge clk);
    check(!rValid && !bValid, "R3", "response released", 32'(rValid | bValid), 0);
  endtask

  function automatic logic [31:0] mkAddr(input int idx, input logic [31:0] r);
    return (r & 32'hFFFF_8FFF) | (32'(idx) << 12);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    check(!rValid && !bValid && pSel == 0 && !pEnable && arReady && awReady, "R12",
          "reset state", {rValid, bValid, pEnable, arReady, awReady}, 32'b00011);

    // every legal slave, reads then writes
    for (int s = 0; s < NS; s++) begin
      logic [31:0] a;
      a = mkAddr(s, $urandom) & 32'hFFFF_FFF3;
      issueRead(a, 4'(s), 0); collect(0, a, 4'(s), 0, 0);
      issueWrite(a ^ 32'h10, 4'(s + 8), 0, 32'hA000_0000 + 32'(s));
      collect(1, a ^ 32'h10, 4'(s + 8), 0, 32'hA000_0000 + 32'(s));
    end
    // slave error (R7), decode error (R9), burst length (R10)
    issueRead(mkAddr(2, 32'h0000_000C), 4'h3, 0); collect(0, mkAddr(2, 32'h0000_000C), 4'h3, 0, 0);
    issueRead(mkAddr(6, 32'h1234_0000), 4'h6, 0); collect(0, mkAddr(6, 32'h1234_0000), 4'h6, 0, 0);
    issueWrite(mkAddr(7, 32'h4), 4'h7, 0, 32'h77); collect(1, mkAddr(7, 32'h4), 4'h7, 0, 32'h77);
    issueRead(mkAddr(1, 32'h8), 4'h9, 8'd3); collect(0, mkAddr(1, 32'h8), 4'h9, 8'd3, 0);
    issueWrite(mkAddr(4, 32'h0), 4'hA, 8'd1, 32'h55); collect(1, mkAddr(4, 32'h0), 4'hA, 8'd1, 32'h55);

    // queue full: one active, two queued, fourth refused (R1)
    stall = 1;
    issueRead(mkAddr(1, 32'h100), 4'h1, 0);
    issueRead(mkAddr(2, 32'h200), 4'h2, 0);
    issueRead(mkAddr(3, 32'h300), 4'h3, 0);
    @(negedge clk); arValid = 1; arAddr = mkAddr(0, 0); #1;
    check(!arReady && !awReady, "R1", "queue full blocks requests", {arReady, awReady}, 0);
    @(negedge clk); arValid = 0; stall = 0;
    collect(0, mkAddr(1, 32'h100), 4'h1, 0, 0);
    collect(0, mkAddr(2, 32'h200), 4'h2, 0, 0);
    collect(0, mkAddr(3, 32'h300), 4'h3, 0, 0);

    // same-cycle read and write, two free slots (R4)
    stall = 1;
    issueRead(mkAddr(5, 32'h40), 4'h4, 0);
    repeat (3) @(negedge clk);
    arAddr = mkAddr(0, 32'h50); arId = 4'h5; arLen = 0; arValid = 1;
    awAddr = mkAddr(1, 32'h60); awId = 4'hB; awLen = 0; wData = 32'hCAFE_0001; awValid = 1; wValid = 1; #1;
    check(arReady && awReady, "R4", "both accepted with two free slots", {arReady, awReady}, 2'b11);
    @(posedge clk); #1; arValid = 0; awValid = 0; wValid = 0;
    stall = 0;
    collect(0, mkAddr(5, 32'h40), 4'h4, 0, 0);
    collect(0, mkAddr(0, 32'h50), 4'h5, 0, 0);
    collect(1, mkAddr(1, 32'h60), 4'hB, 0, 32'hCAFE_0001);

    // same-cycle read and write, one free slot: read wins (R4)
    stall = 1;
    issueRead(mkAddr(2, 32'h70), 4'h2, 0);
    repeat (3) @(negedge clk);
    issueRead(mkAddr(3, 32'h74), 4'h3, 0);
    @(negedge clk);
    arAddr = mkAddr(4, 32'h78); arId = 4'h4; arValid = 1;
    awAddr = mkAddr(5, 32'h7C); awId = 4'hC; wData = 32'h1; awValid = 1; wValid = 1; #1;
    check(arReady && !awReady && !wReady, "R4", "read takes last slot", {arReady, awReady}, 2'b10);
    @(posedge clk); #1; arValid = 0; awValid = 0; wValid = 0;
    stall = 0;
    collect(0, mkAddr(2, 32'h70), 4'h2, 0, 0);
    collect(0, mkAddr(3, 32'h74), 4'h3, 0, 0);
    collect(0, mkAddr(4, 32'h78), 4'h4, 0, 0);

    // constrained random mix
    for (int n = 0; n < 40; n++) begin
      logic [31:0] a, d; logic [7:0] len; logic [3:0] id; bit wr;
      a = mkAddr($urandom % 8, $urandom);
      len = ($urandom % 8 == 0) ? 8'(1 + $urandom % 3) : 8'd0;
      id = 4'($urandom); d = $urandom; wr = $urandom % 2;
      if (wr) begin issueWrite(a, id, len, d); collect(1, a, id, len, d); end
      else    begin issueRead(a, id, len);     collect(0, a, id, len, 0); end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule